// File: doc/BRIEF.md
# Two-Level Branch Direction Predictor with Prediction Queue

This block predicts whether conditional branches are taken. A fetch request presents a branch address. A small first-level table of 2-bit counters answers in that same cycle. Its answer is written, with a sequence number, into an eight-entry prediction queue. The front end drains the queue in order.

The same request also starts a lookup in a much larger second-level table. That table uses the same counters, but each entry also carries an address tag. The second-level answer completes three clock edges later. If the queued entry is still waiting, the slower answer quietly replaces its direction. If the entry has already left the queue and the two answers disagree, the block emits a one-cycle late-correction pulse that names the entry. Resolved branches train both tables through a plain update port. A flush empties the queue and cancels every lookup still in flight.

The request port and the dequeue port are valid/ready streams. A request is accepted only in a cycle where both `req_valid` and `req_ready` are high. `req_ready` drops while the queue holds eight entries or while `flush` is high. An entry leaves the queue in a cycle where both `deq_valid` and `deq_ready` are high. While `deq_ready` is low, the head entry stays in place. The update port, the flush input and the late-correction output have no handshake.

Top module: `bp_two_level`

## Requirements
- R1: After reset the queue is empty, `req_ready` is 1, `deq_valid` and `late_valid` are 0, and every counter holds 1 (weakly not-taken), so `pred_taken` is 0 for any address.
- R2: `pred_taken` is the upper bit of the first-level counter indexed by `req_pc[3:0]`. It is combinational in the same cycle, and taken is encoded as 1.
- R3: An accepted request appends an entry holding `pred_taken` and a sequence number. Sequence numbers start at 0 after reset and increase by 1 per accepted request, modulo 64. `req_ready` is 0 while eight entries are queued or while `flush` is 1.
- R4: Entries leave in the order they were accepted. While `deq_valid` is 1 and `deq_ready` is 0, the same entry stays presented on the next cycle unless a flush intervenes.
- R5: For each accepted request, the second-level table is read in the acceptance cycle. Its index is `req_pc[7:0]` and its tag is `req_pc[15:8]`. On a tag hit the second-level direction is the counter's upper bit. On a miss it equals the first-level direction. The second-level direction completes at the third rising edge after acceptance.
- R6: If the entry is still queued at the completion edge and does not leave the queue at that edge, its direction is replaced by the second-level direction.
- R7: If the entry has already left, or leaves at the completion edge, and the two directions differ, then for one cycle after that edge `late_valid` is 1, `late_seq` holds the entry's sequence number and `late_taken` holds the second-level direction.
- R8: When `upd_valid` is 1, the first-level counter moves toward `upd_taken` (up on taken, down on not-taken, saturating at 0 and 3). A second-level tag hit moves its counter the same way. A miss installs the tag and sets the counter to 2 if taken or 1 if not-taken. Lookups in the same cycle see the counters as they were before the update.
- R9: While `flush` is 1, the request and dequeue ports are closed. At the next edge the queue empties, all in-flight lookups are dropped and no late correction is raised for them. Updates still apply.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty the queue and cancel in-flight lookups |
| req_valid | input | 1 | Prediction request valid |
| req_ready | output | 1 | Request can be accepted |
| req_pc | input | 16 | Branch address |
| pred_taken | output | 1 | Same-cycle first-level direction |
| deq_valid | output | 1 | Queue head valid |
| deq_ready | input | 1 | Consumer takes the head entry |
| deq_taken | output | 1 | Direction of the head entry |
| deq_seq | output | 6 | Sequence number of the head entry |
| upd_valid | input | 1 | Resolved branch update valid |
| upd_pc | input | 16 | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction |
| late_valid | output | 1 | Late-correction pulse |
| late_seq | output | 6 | Sequence number being corrected |
| late_taken | output | 1 | Corrected direction |

## Verification
Every cycle, the assertions check the following properties:
- No push happens into a full queue, and no pop happens from an empty one.
- A flush leaves the queue empty.
- The head entry holds steady under back-pressure.
- A late pulse only ever follows a completing lookup.
- A lookup that rewrote a queued entry never also raises a late pulse.

Some behaviours can only be shown by the bench's scenarios, which compare the block against a cycle-by-cycle reference model:
- the actual directions, including counter saturation and tag replacement;
- the choice between a silent override and a late correction when completion and dequeue coincide;
- the cancelling of lookups by a flush.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_WEAK_NT = 2'd1;
  localparam ctr_t CTR_WEAK_T  = 2'd2;

  // saturating 2-bit step toward the resolved direction
  function automatic ctr_t ctr_step(input ctr_t c, input logic taken);
    ctr_t n;
    n = c;
    if (taken && c != 2'd3) n = c + 2'd1;
    else if (!taken && c != 2'd0) n = c - 2'd1;
    return n;
  endfunction

endpackage

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
  import bp_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int TAG_W = 0,
  localparam int KEY_W = IDX_W + TAG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [KEY_W-1:0] lk_key,
  output logic             lk_hit,
  output logic             lk_taken,
  input  logic             up_valid,
  input  logic [KEY_W-1:0] up_key,
  input  logic             up_taken
);
  localparam int N = 1 << IDX_W;

  logic [IDX_W-1:0] lk_idx, up_idx;
  assign lk_idx = lk_key[IDX_W-1:0];
  assign up_idx = up_key[IDX_W-1:0];

  generate
    if (TAG_W == 0) begin : g_plain
      ctr_t ctr_q [N];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < N; i++) ctr_q[i] <= CTR_WEAK_NT;
        end else if (up_valid) begin
          ctr_q[up_idx] <= ctr_step(ctr_q[up_idx], up_taken);
        end
      end

      assign lk_hit   = 1'b1;
      assign lk_taken = ctr_q[lk_idx][1];
    end else begin : g_tagged
      ctr_t             ctr_q [N];
      logic [TAG_W-1:0] tag_q [N];
      logic [N-1:0]     vld_q;
      logic [TAG_W-1:0] lk_tag, up_tag;
      logic             up_hit;

      assign lk_tag = lk_key[KEY_W-1:IDX_W];
      assign up_tag = up_key[KEY_W-1:IDX_W];
      assign up_hit = vld_q[up_idx] && (tag_q[up_idx] == up_tag);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q <= '0;
          for (int i = 0; i < N; i++) begin
            ctr_q[i] <= CTR_WEAK_NT;
            tag_q[i] <= '0;
          end
        end else if (up_valid) begin
          if (up_hit) begin
            ctr_q[up_idx] <= ctr_step(ctr_q[up_idx], up_taken);
          end else begin
            ctr_q[up_idx] <= up_taken ? CTR_WEAK_T : CTR_WEAK_NT;
            tag_q[up_idx] <= up_tag;
            vld_q[up_idx] <= 1'b1;
          end
        end
      end

      assign lk_hit   = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
      assign lk_taken = ctr_q[lk_idx][1];
    end
  endgenerate

endmodule

// File: rtl/bp_queue.sv
module bp_queue #(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 6,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic             push_taken,
  output logic [SEQ_W-1:0] tail_seq,
  output logic             full,
  input  logic             pop,
  output logic             head_valid,
  output logic             head_taken,
  output logic [SEQ_W-1:0] head_seq,
  input  logic             fix_valid,
  input  logic [SEQ_W-1:0] fix_seq,
  input  logic             fix_taken,
  output logic             fix_hit
);
  logic [DEPTH-1:0] taken_q;
  logic [DEPTH-1:0] vld_q;
  logic [SEQ_W-1:0] seq_q [DEPTH];
  logic [PTR_W-1:0] head_q;
  logic [PTR_W:0]   cnt_q;
  logic [SEQ_W-1:0] seq_ctr_q;
  logic [PTR_W-1:0] tail_slot, fix_slot;

  // slot of an entry is the low bits of its sequence number
  assign tail_slot = seq_ctr_q[PTR_W-1:0];
  assign fix_slot  = fix_seq[PTR_W-1:0];
  assign tail_seq  = seq_ctr_q;
  assign full      = (cnt_q == (PTR_W+1)'(DEPTH));
  assign head_valid = (cnt_q != '0);
  assign head_taken = taken_q[head_q];
  assign head_seq   = seq_q[head_q];

  assign fix_hit = fix_valid && vld_q[fix_slot] && (seq_q[fix_slot] == fix_seq)
                   && !(pop && (fix_slot == head_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken_q   <= '0;
      vld_q     <= '0;
      head_q    <= '0;
      cnt_q     <= '0;
      seq_ctr_q <= '0;
      for (int i = 0; i < DEPTH; i++) seq_q[i] <= '0;
    end else if (flush) begin
      vld_q  <= '0;
      cnt_q  <= '0;
      head_q <= tail_slot;
    end else begin
      if (fix_hit) taken_q[fix_slot] <= fix_taken;
      if (pop) begin
        vld_q[head_q] <= 1'b0;
        head_q        <= head_q + 1'b1;
      end
      if (push) begin
        taken_q[tail_slot] <= push_taken;
        seq_q[tail_slot]   <= seq_ctr_q;
        vld_q[tail_slot]   <= 1'b1;
        seq_ctr_q          <= seq_ctr_q + 1'b1;
      end
      cnt_q <= cnt_q + (PTR_W+1)'(push) - (PTR_W+1)'(pop);
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q < (PTR_W+1)'(DEPTH)));

  p_pop_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0));

  p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0) && (vld_q == '0));

endmodule

// File: rtl/bp_two_level.sv
module bp_two_level #(
  parameter int PC_W   = 16,
  parameter int L1_IDX = 4,
  parameter int L2_IDX = 8,
  parameter int QDEPTH = 8,
  parameter int SEQ_W  = 6,
  parameter int L2_LAT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [PC_W-1:0]  req_pc,
  output logic             pred_taken,
  output logic             deq_valid,
  input  logic             deq_ready,
  output logic             deq_taken,
  output logic [SEQ_W-1:0] deq_seq,
  input  logic             upd_valid,
  input  logic [PC_W-1:0]  upd_pc,
  input  logic             upd_taken,
  output logic             late_valid,
  output logic [SEQ_W-1:0] late_seq,
  output logic             late_taken
);
  localparam int L2_TAG = PC_W - L2_IDX;

  typedef struct packed {
    logic             v;
    logic [SEQ_W-1:0] seq;
    logic             l1;
    logic             l2;
  } lookup_t;

  logic l1_hit, l1_dir, l2_hit, l2_ctr_dir, l2_dir;
  logic accept, pop, q_full, q_head_valid, fix_hit, done;
  logic [SEQ_W-1:0] tail_seq;
  lookup_t pipe_q [L2_LAT];
  lookup_t last;

  bp_ctr_table #(.IDX_W(L1_IDX), .TAG_W(0)) u_l1 (
    .clk(clk), .rst_n(rst_n),
    .lk_key(req_pc[L1_IDX-1:0]), .lk_hit(l1_hit), .lk_taken(l1_dir),
    .up_valid(upd_valid), .up_key(upd_pc[L1_IDX-1:0]), .up_taken(upd_taken)
  );

  bp_ctr_table #(.IDX_W(L2_IDX), .TAG_W(L2_TAG)) u_l2 (
    .clk(clk), .rst_n(rst_n),
    .lk_key(req_pc), .lk_hit(l2_hit), .lk_taken(l2_ctr_dir),
    .up_valid(upd_valid), .up_key(upd_pc), .up_taken(upd_taken)
  );

  assign pred_taken = l1_hit & l1_dir;
  assign l2_dir     = l2_hit ? l2_ctr_dir : pred_taken;

  assign req_ready = !q_full && !flush;
  assign accept    = req_valid && req_ready;
  assign deq_valid = q_head_valid && !flush;
  assign pop       = deq_valid && deq_ready;

  // fixed-latency second-level result pipeline
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < L2_LAT; s++) pipe_q[s] <= '0;
    end else if (flush) begin
      for (int s = 0; s < L2_LAT; s++) pipe_q[s] <= '0;
    end else begin
      pipe_q[0] <= '{v: accept, seq: tail_seq, l1: pred_taken, l2: l2_dir};
      for (int s = 1; s < L2_LAT; s++) pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign last = pipe_q[L2_LAT-1];
  assign done = last.v && !flush;

  bp_queue #(.DEPTH(QDEPTH), .SEQ_W(SEQ_W)) u_q (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(accept), .push_taken(pred_taken), .tail_seq(tail_seq), .full(q_full),
    .pop(pop), .head_valid(q_head_valid), .head_taken(deq_taken), .head_seq(deq_seq),
    .fix_valid(done), .fix_seq(last.seq), .fix_taken(last.l2), .fix_hit(fix_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      late_valid <= 1'b0;
      late_seq   <= '0;
      late_taken <= 1'b0;
    end else begin
      late_valid <= done && !fix_hit && (last.l2 != last.l1);
      late_seq   <= last.seq;
      late_taken <= last.l2;
    end
  end

  p_late_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    late_valid |-> $past(last.v && !flush));

  p_override_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fix_hit) |=> !late_valid);

  p_head_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_valid && !deq_ready && !flush) |=> (flush || (deq_valid && deq_seq == $past(deq_seq))));

  p_ready_closed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!req_ready && !deq_valid));

endmodule

// File: tb/bp_two_level_test.sv
module bp_two_level_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_pc = '0;
  logic        pred_taken;
  logic        deq_valid;
  logic        deq_ready = 1'b0;
  logic        deq_taken;
  logic [5:0]  deq_seq;
  logic        upd_valid = 1'b0;
  logic [15:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic        late_valid;
  logic [5:0]  late_seq;
  logic        late_taken;

  always #5 clk = ~clk;

  bp_two_level uut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .req_valid(req_valid), .req_ready(req_ready), .req_pc(req_pc), .pred_taken(pred_taken),
    .deq_valid(deq_valid), .deq_ready(deq_ready), .deq_taken(deq_taken), .deq_seq(deq_seq),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .late_valid(late_valid), .late_seq(late_seq), .late_taken(late_taken)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  string phase = "R1";

  // behavioural reference state
  int m_l1 [16];
  int m_l2c [256];
  int m_l2t [256];
  bit m_l2v [256];
  int mq_seq [$];
  bit mq_tk [$];
  int fs_seq [$];
  int fs_cnt [$];
  bit fs_l1 [$];
  bit fs_l2 [$];
  int m_seq = 0;
  bit m_late_v = 0;
  int m_late_s = 0;
  bit m_late_t = 0;

  function automatic int sat(int c, bit t);
    if (t) return (c < 3) ? c + 1 : 3;
    return (c > 0) ? c - 1 : 0;
  endfunction

  task automatic chk(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s [phase %s] actual=%0d expected=%0d at %0t", what, phase, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit exp_ready, exp_dv;
    exp_ready = (mq_seq.size() < 8) && !flush;
    exp_dv = (mq_seq.size() > 0) && !flush;
    chk("R3 req_ready", req_ready, exp_ready);
    chk("R2 pred_taken", pred_taken, m_l1[req_pc[3:0]] >= 2);
    chk("R4 deq_valid", deq_valid, exp_dv);
    if (exp_dv) begin
      chk("R6 deq_taken", deq_taken, mq_tk[0]);
      chk("R3 deq_seq", deq_seq, mq_seq[0]);
    end
    chk("R7 late_valid", late_valid, m_late_v);
    if (m_late_v) begin
      chk("R7 late_seq", late_seq, m_late_s);
      chk("R7 late_taken", late_taken, m_late_t);
    end
  endtask

  task automatic model_step();
    bit l1p, l2p, hit, acc, pp, nv, found;
    int idx, tg, k, nseq;
    bit nt;
    l1p = m_l1[req_pc[3:0]] >= 2;
    idx = req_pc[7:0];
    tg  = req_pc[15:8];
    hit = m_l2v[idx] && (m_l2t[idx] == tg);
    l2p = hit ? (m_l2c[idx] >= 2) : l1p;
    acc = req_valid && (mq_seq.size() < 8) && !flush;
    pp  = deq_ready && (mq_seq.size() > 0) && !flush;
    nv = 0; nseq = 0; nt = 0;
    if (flush) begin
      mq_seq.delete(); mq_tk.delete();
      fs_seq.delete(); fs_cnt.delete(); fs_l1.delete(); fs_l2.delete();
    end else begin
      if (fs_seq.size() > 0 && fs_cnt[0] == 2) begin
        found = 0; k = 0;
        for (int i = 0; i < mq_seq.size(); i++)
          if (mq_seq[i] == fs_seq[0]) begin found = 1; k = i; end
        if (found && !(pp && k == 0)) mq_tk[k] = fs_l2[0];
        else if (fs_l2[0] != fs_l1[0]) begin nv = 1; nseq = fs_seq[0]; nt = fs_l2[0]; end
        void'(fs_seq.pop_front()); void'(fs_cnt.pop_front());
        void'(fs_l1.pop_front()); void'(fs_l2.pop_front());
      end
      for (int i = 0; i < fs_cnt.size(); i++) fs_cnt[i] = fs_cnt[i] + 1;
      if (pp) begin void'(mq_seq.pop_front()); void'(mq_tk.pop_front()); end
      if (acc) begin
        mq_seq.push_back(m_seq); mq_tk.push_back(l1p);
        fs_seq.push_back(m_seq); fs_cnt.push_back(0);
        fs_l1.push_back(l1p); fs_l2.push_back(l2p);
        m_seq = (m_seq + 1) % 64;
      end
    end
    if (upd_valid) begin
      m_l1[upd_pc[3:0]] = sat(m_l1[upd_pc[3:0]], upd_taken);
      idx = upd_pc[7:0];
      tg  = upd_pc[15:8];
      if (m_l2v[idx] && m_l2t[idx] == tg) m_l2c[idx] = sat(m_l2c[idx], upd_taken);
      else begin m_l2v[idx] = 1; m_l2t[idx] = tg; m_l2c[idx] = upd_taken ? 2 : 1; end
    end
    m_late_v = nv; m_late_s = nseq; m_late_t = nt;
  endtask

  task automatic tick(bit rv, int pc, bit dr, bit uv, int upc, bit ut, bit fl);
    @(negedge clk);
    req_valid = rv; req_pc = 16'(pc); deq_ready = dr;
    upd_valid = uv; upd_pc = 16'(upc); upd_taken = ut; flush = fl;
    #1;
    compare();
    @(posedge clk);
    model_step();
  endtask

  initial begin
    for (int i = 0; i < 16; i++) m_l1[i] = 1;
    for (int i = 0; i < 256; i++) begin m_l2c[i] = 1; m_l2t[i] = 0; m_l2v[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    phase = "R1";
    #1;
    chk("R1 req_ready", req_ready, 1);
    chk("R1 deq_valid", deq_valid, 0);
    chk("R1 late_valid", late_valid, 0);
    chk("R1 pred_taken", pred_taken, 0);
    tick(0, 16'h0013, 0, 0, 0, 0, 0);

    // R8: training, saturation and tag install; R2 watched through pred_taken
    phase = "R8";
    for (int i = 0; i < 5; i++) tick(1, 16'h0013, 1, 1, 16'h0013, 1, 0);
    for (int i = 0; i < 6; i++) tick(1, 16'h0023, 1, 1, 16'h0023, 0, 0);
    for (int i = 0; i < 3; i++) tick(1, 16'h0155, 1, 1, 16'h0155, 1, 0);
    for (int i = 0; i < 2; i++) tick(1, 16'h0255, 1, 1, 16'h0255, 0, 0);
    repeat (5) tick(0, 0, 1, 0, 0, 0, 0);

    // R5/R6: fill the queue while L1 and L2 disagree, nothing dequeued
    phase = "R5";
    for (int i = 0; i < 10; i++) tick(1, (i % 2) ? 16'h0013 : 16'h0155, 0, 0, 0, 0, 0);
    repeat (4) tick(0, 0, 0, 0, 0, 0, 0);
    repeat (10) tick(0, 0, 1, 0, 0, 0, 0);

    // R7: immediate dequeue, completion arrives after consumption
    phase = "R7";
    for (int i = 0; i < 8; i++) tick(1, 16'h0013, 1, 0, 0, 0, 0);
    repeat (5) tick(0, 0, 1, 0, 0, 0, 0);
    // completion in the same cycle as dequeue of that entry
    tick(1, 16'h0013, 0, 0, 0, 0, 0);
    tick(0, 0, 0, 0, 0, 0, 0);
    tick(0, 0, 0, 0, 0, 0, 0);
    tick(0, 0, 1, 0, 0, 0, 0);
    repeat (3) tick(0, 0, 1, 0, 0, 0, 0);

    // R9: flush with lookups in flight, updates still land
    phase = "R9";
    tick(1, 16'h0013, 1, 0, 0, 0, 0);
    tick(1, 16'h0013, 0, 0, 0, 0, 0);
    tick(1, 16'h0155, 0, 1, 16'h0013, 1, 1);
    repeat (5) tick(0, 16'h0013, 1, 0, 0, 0, 0);

    // R4: random back-pressure mix
    phase = "R4";
    for (int i = 0; i < 3000; i++) begin
      int pcs [6];
      int pc, upc;
      pcs = '{16'h0013, 16'h0023, 16'h0155, 16'h0255, 16'h0A45, 0};
      pc  = pcs[$urandom_range(5, 0)];
      if (pc == 0) pc = $urandom_range(16'hFFFF, 0);
      upc = pcs[$urandom_range(4, 0)];
      tick($urandom_range(99, 0) < 70, pc, $urandom_range(99, 0) < 45,
           $urandom_range(99, 0) < 40, upc, $urandom_range(1, 0) == 1,
           $urandom_range(99, 0) < 2);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired in phase %s", phase);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule